// File: doc/BRIEF.md
# Grayscale Pixel Packer

This block sits between a host byte bus and a 32-bit display memory. On the write side it collects 4-bit grayscale pixels (16 levels) from host data bytes. It places them in order into a 32-bit word and issues one memory write only when the word holds eight pixels. A 2-bit format input selects how a byte carries pixels. It can carry two pixels, high nibble first or low nibble first. It can also carry one pixel, taken from the high nibble or from the low nibble, with the other nibble discarded.

On the read side the host pulls bytes. The first read after reset or after an address load returns a dummy byte and starts a fetch of the current word. Each later group of four reads returns that word most significant byte first, and the fourth read of a group fetches the next word. One pair of counters (row, and column in words) forms the memory address for both directions. The pair steps after every word write and every word fetch. The memory is an external synchronous array that returns read data one clock after a read request. Host read strobes must be at least three clock cycles apart so that a fetched word arrives before it is needed.

Top module: `gray_pixel_packer`

## Requirements
- R1: After synchronous reset, mem_we_o and mem_re_o are 0, rd_data_o is 0x00, and the row and column counters are both 0.
- R2: With format 0, the high nibble of a written byte is the earlier pixel and the low nibble the later one. The first pixel of a word lands in bits 31:28, and each following pixel sits 4 bits lower.
- R3: With format 1, the low nibble of a written byte is the earlier pixel and the high nibble the later one, with the same in-word order as R2.
- R4: With format 2, only the high nibble is taken as one pixel. With format 3, only the low nibble is taken. The other nibble has no effect on the stored word.
- R5: mem_we_o pulses for exactly one cycle, in the cycle after the write strobe that brings the word to eight pixels, carrying that word on mem_wdata_o. Strobes that leave the word short of eight pixels cause no memory write.
- R6: The memory address is row*20+column. It steps by one after each word write or word fetch. The column wraps from 19 to 0 and increments the row, and the row wraps from 159 to 0, so address 3199 is followed by 0.
- R7: Loading the row or column counter takes priority over host strobes in that cycle. It discards any partly filled write word and makes the next read a dummy read again.
- R8: The first read strobe after reset or a counter load returns 0x00 in the next cycle. In that same cycle it raises mem_re_o with mem_addr_o at the current address.
- R9: Each later read returns the next byte of the fetched word, most significant byte first. The fourth read of a group also raises mem_re_o for the next word. rd_data_o changes only in the cycle after a read strobe and holds otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fmt_i | input | 2 | Pixel format code (0..3) |
| row_load_i | input | 1 | Load the row counter |
| row_val_i | input | 8 | Row value to load |
| col_load_i | input | 1 | Load the column counter |
| col_val_i | input | 5 | Column (word) value to load |
| wr_stb_i | input | 1 | Host display-data write strobe, one cycle |
| wr_data_i | input | 8 | Host write byte |
| rd_stb_i | input | 1 | Host display-data read strobe, one cycle |
| rd_data_o | output | 8 | Host read byte, registered |
| mem_we_o | output | 1 | Memory write enable |
| mem_re_o | output | 1 | Memory read request |
| mem_addr_o | output | 12 | Memory word address |
| mem_wdata_o | output | 32 | Memory write word |
| mem_rdata_i | input | 32 | Memory read word, valid one cycle after mem_re_o |

## Verification
A write strobe sampled on a rising edge shows its result one cycle later. mem_we_o, mem_addr_o and mem_wdata_o change at that same edge, so the bench drops the strobe on the following falling edge and checks the memory outputs right there. A read strobe likewise updates rd_data_o and, when a fetch is due, mem_re_o and mem_addr_o at the edge that samples it, and these are checked on the next falling edge. A fetched word reaches the read buffer two edges after the request. The bench therefore leaves three idle cycles between read strobes and checks that rd_data_o has not moved in those idle cycles.

// File: rtl/gpp_pkg.sv
package gpp_pkg;
  typedef enum logic [1:0] {
    FMT_HI_FIRST = 2'd0,
    FMT_LO_FIRST = 2'd1,
    FMT_HI_ONLY  = 2'd2,
    FMT_LO_ONLY  = 2'd3
  } pix_fmt_e;
endpackage

// File: rtl/gpp_addr_ctr.sv
module gpp_addr_ctr #(
  parameter int ROWS = 160,
  parameter int COLS = 20,
  localparam int ROW_W = $clog2(ROWS),
  localparam int COL_W = $clog2(COLS),
  localparam int AW    = $clog2(ROWS * COLS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             row_load_i,
  input  logic [ROW_W-1:0] row_val_i,
  input  logic             col_load_i,
  input  logic [COL_W-1:0] col_val_i,
  input  logic             adv_i,
  output logic [AW-1:0]    addr_o
);
  localparam logic [COL_W-1:0] COL_LAST = COL_W'(COLS - 1);
  localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(ROWS - 1);
  localparam logic [AW-1:0]    ADDR_LAST = AW'(ROWS * COLS - 1);

  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      row_q <= '0;
      col_q <= '0;
    end else if (row_load_i || col_load_i) begin
      if (row_load_i) row_q <= row_val_i;
      if (col_load_i) col_q <= col_val_i;
    end else if (adv_i) begin
      if (col_q == COL_LAST) begin
        col_q <= '0;
        row_q <= (row_q == ROW_LAST) ? '0 : row_q + ROW_W'(1);
      end else begin
        col_q <= col_q + COL_W'(1);
      end
    end
  end

  assign addr_o = AW'(row_q) * AW'(COLS) + AW'(col_q);

  assert_addr_step_R6: assert property (@(posedge clk) disable iff (rst)
    (adv_i && !row_load_i && !col_load_i && addr_o < ADDR_LAST) |=> (addr_o == $past(addr_o) + AW'(1)));
  assert_addr_wrap_R6: assert property (@(posedge clk) disable iff (rst)
    (adv_i && !row_load_i && !col_load_i && addr_o == ADDR_LAST) |=> (addr_o == '0));
  assert_row_load_R7: assert property (@(posedge clk) disable iff (rst)
    row_load_i |=> (row_q == $past(row_val_i)));
  assert_col_load_R7: assert property (@(posedge clk) disable iff (rst)
    col_load_i |=> (col_q == $past(col_val_i)));
endmodule

// File: rtl/gpp_wr_pack.sv
module gpp_wr_pack
  import gpp_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int WORD_W = 32,
  localparam int PIX_W = DATA_W / 2,
  localparam int PPW   = WORD_W / PIX_W,
  localparam int CNT_W = $clog2(PPW + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_i,
  input  logic              stb_i,
  input  logic [1:0]        fmt_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              done_o,
  output logic              we_o,
  output logic [WORD_W-1:0] word_o
);
  logic [WORD_W-1:0] acc_q, acc_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [PIX_W-1:0]  hi, lo, first, second;
  logic              pair;
  pix_fmt_e          fmt;

  assign fmt = pix_fmt_e'(fmt_i);
  assign hi  = data_i[DATA_W-1 -: PIX_W];
  assign lo  = data_i[PIX_W-1:0];

  always_comb begin
    pair   = 1'b0;
    first  = hi;
    second = lo;
    unique case (fmt)
      FMT_HI_FIRST: begin pair = 1'b1; first = hi; second = lo; end
      FMT_LO_FIRST: begin pair = 1'b1; first = lo; second = hi; end
      FMT_HI_ONLY:  begin first = hi; end
      FMT_LO_ONLY:  begin first = lo; end
      default:      begin first = hi; end
    endcase
  end

  always_comb begin
    acc_n = acc_q;
    cnt_n = cnt_q;
    if (pair && cnt_q <= CNT_W'(PPW - 2)) begin
      acc_n = {acc_q[WORD_W-2*PIX_W-1:0], first, second};
      cnt_n = cnt_q + CNT_W'(2);
    end else begin
      acc_n = {acc_q[WORD_W-PIX_W-1:0], first};
      cnt_n = cnt_q + CNT_W'(1);
    end
  end

  assign done_o = stb_i && !clr_i && (cnt_n == CNT_W'(PPW));

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q  <= '0;
      cnt_q  <= '0;
      we_o   <= 1'b0;
      word_o <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
      we_o  <= 1'b0;
    end else begin
      we_o <= done_o;
      if (stb_i) begin
        acc_q <= acc_n;
        cnt_q <= done_o ? '0 : cnt_n;
        if (done_o) word_o <= acc_n;
      end
    end
  end

  assert_we_single_R5: assert property (@(posedge clk) disable iff (rst)
    we_o |=> !we_o);
  assert_no_early_write_R5: assert property (@(posedge clk) disable iff (rst)
    (stb_i && !clr_i && cnt_q == '0) |=> !we_o);
  assert_clear_R7: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (!we_o && cnt_q == '0));
endmodule

// File: rtl/gpp_rd_unpack.sv
module gpp_rd_unpack #(
  parameter int DATA_W = 8,
  parameter int WORD_W = 32,
  localparam int BYTES = WORD_W / DATA_W,
  localparam int IDX_W = $clog2(BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_i,
  input  logic              stb_i,
  input  logic [WORD_W-1:0] mem_rdata_i,
  output logic              fetch_o,
  output logic              mem_re_o,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(BYTES - 1);

  logic              primed_q;
  logic              land_q;
  logic [IDX_W-1:0]  idx_q;
  logic [WORD_W-1:0] rbuf_q;

  assign fetch_o = stb_i && !clr_i && (!primed_q || idx_q == IDX_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      primed_q  <= 1'b0;
      land_q    <= 1'b0;
      idx_q     <= '0;
      rbuf_q    <= '0;
      mem_re_o  <= 1'b0;
      rd_data_o <= '0;
    end else if (clr_i) begin
      primed_q <= 1'b0;
      land_q   <= 1'b0;
      idx_q    <= '0;
      mem_re_o <= 1'b0;
    end else begin
      mem_re_o <= fetch_o;
      land_q   <= mem_re_o;
      if (land_q) rbuf_q <= mem_rdata_i;
      if (stb_i) begin
        if (!primed_q) begin
          rd_data_o <= '0;
          primed_q  <= 1'b1;
          idx_q     <= '0;
        end else begin
          rd_data_o <= rbuf_q[(BYTES - 1 - int'(idx_q)) * DATA_W +: DATA_W];
          idx_q     <= idx_q + IDX_W'(1);
        end
      end
    end
  end

  assert_dummy_read_R8: assert property (@(posedge clk) disable iff (rst)
    (stb_i && !clr_i && !primed_q) |=> (rd_data_o == '0 && mem_re_o));
  assert_group_fetch_R9: assert property (@(posedge clk) disable iff (rst)
    (stb_i && !clr_i && primed_q && idx_q == IDX_LAST) |=> mem_re_o);
  assert_data_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !stb_i |=> $stable(rd_data_o));
endmodule

// File: rtl/gray_pixel_packer.sv
module gray_pixel_packer #(
  parameter int ROWS   = 160,
  parameter int COLS   = 20,
  parameter int DATA_W = 8,
  parameter int WORD_W = 32,
  localparam int ROW_W = $clog2(ROWS),
  localparam int COL_W = $clog2(COLS),
  localparam int AW    = $clog2(ROWS * COLS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        fmt_i,
  input  logic              row_load_i,
  input  logic [ROW_W-1:0]  row_val_i,
  input  logic              col_load_i,
  input  logic [COL_W-1:0]  col_val_i,
  input  logic              wr_stb_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_stb_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              mem_we_o,
  output logic              mem_re_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  input  logic [WORD_W-1:0] mem_rdata_i
);
  logic          clr;
  logic          rd_go;
  logic          wr_done;
  logic          rd_fetch;
  logic [AW-1:0] addr;

  assign clr   = row_load_i | col_load_i;
  assign rd_go = rd_stb_i & ~wr_stb_i;

  gpp_addr_ctr #(.ROWS(ROWS), .COLS(COLS)) u_ctr (
    .clk        (clk),
    .rst        (rst),
    .row_load_i (row_load_i),
    .row_val_i  (row_val_i),
    .col_load_i (col_load_i),
    .col_val_i  (col_val_i),
    .adv_i      (wr_done | rd_fetch),
    .addr_o     (addr)
  );

  gpp_wr_pack #(.DATA_W(DATA_W), .WORD_W(WORD_W)) u_wr (
    .clk    (clk),
    .rst    (rst),
    .clr_i  (clr),
    .stb_i  (wr_stb_i),
    .fmt_i  (fmt_i),
    .data_i (wr_data_i),
    .done_o (wr_done),
    .we_o   (mem_we_o),
    .word_o (mem_wdata_o)
  );

  gpp_rd_unpack #(.DATA_W(DATA_W), .WORD_W(WORD_W)) u_rd (
    .clk         (clk),
    .rst         (rst),
    .clr_i       (clr),
    .stb_i       (rd_go),
    .mem_rdata_i (mem_rdata_i),
    .fetch_o     (rd_fetch),
    .mem_re_o    (mem_re_o),
    .rd_data_o   (rd_data_o)
  );

  always_ff @(posedge clk) begin
    if (rst) mem_addr_o <= '0;
    else if (wr_done || rd_fetch) mem_addr_o <= addr;
  end

  assert_we_re_apart_R5: assert property (@(posedge clk) disable iff (rst)
    !(mem_we_o && mem_re_o));
  assert_write_addr_R6: assert property (@(posedge clk) disable iff (rst)
    wr_done |=> (mem_addr_o == $past(addr)));
endmodule

// File: tb/test_gray_pixel_packer.sv
module test_gray_pixel_packer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  fmt = 2'd0;
  logic        row_load = 1'b0, col_load = 1'b0;
  logic [7:0]  row_val = '0;
  logic [4:0]  col_val = '0;
  logic        wr_stb = 1'b0, rd_stb = 1'b0;
  logic [7:0]  wr_data = '0;
  logic [7:0]  rd_data;
  logic        mem_we, mem_re;
  logic [11:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic [31:0] bmem [16];
  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  gray_pixel_packer i_gray_pixel_packer (
    .clk(clk), .rst(rst), .fmt_i(fmt),
    .row_load_i(row_load), .row_val_i(row_val),
    .col_load_i(col_load), .col_val_i(col_val),
    .wr_stb_i(wr_stb), .wr_data_i(wr_data),
    .rd_stb_i(rd_stb), .rd_data_o(rd_data),
    .mem_we_o(mem_we), .mem_re_o(mem_re), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata)
  );

  always_ff @(posedge clk) if (mem_re) mem_rdata <= bmem[mem_addr[3:0]];

  // {fmt[54:53], byte[52:45], write expected[44], addr[43:32], word[31:0]}
  localparam logic [54:0] VEC [24] = '{
    {2'd0, 8'h12, 1'b0, 12'd0, 32'h0}, {2'd0, 8'h34, 1'b0, 12'd0, 32'h0},
    {2'd0, 8'h56, 1'b0, 12'd0, 32'h0}, {2'd0, 8'h78, 1'b1, 12'd0, 32'h12345678},
    {2'd1, 8'h21, 1'b0, 12'd0, 32'h0}, {2'd1, 8'h43, 1'b0, 12'd0, 32'h0},
    {2'd1, 8'h65, 1'b0, 12'd0, 32'h0}, {2'd1, 8'h87, 1'b1, 12'd1, 32'h12345678},
    {2'd2, 8'hA0, 1'b0, 12'd0, 32'h0}, {2'd2, 8'hB5, 1'b0, 12'd0, 32'h0},
    {2'd2, 8'hC0, 1'b0, 12'd0, 32'h0}, {2'd2, 8'hDF, 1'b0, 12'd0, 32'h0},
    {2'd2, 8'hE0, 1'b0, 12'd0, 32'h0}, {2'd2, 8'hF0, 1'b0, 12'd0, 32'h0},
    {2'd2, 8'h10, 1'b0, 12'd0, 32'h0}, {2'd2, 8'h2F, 1'b1, 12'd2, 32'hABCDEF12},
    {2'd3, 8'h03, 1'b0, 12'd0, 32'h0}, {2'd3, 8'hF4, 1'b0, 12'd0, 32'h0},
    {2'd3, 8'h05, 1'b0, 12'd0, 32'h0}, {2'd3, 8'h06, 1'b0, 12'd0, 32'h0},
    {2'd3, 8'hA7, 1'b0, 12'd0, 32'h0}, {2'd3, 8'h08, 1'b0, 12'd0, 32'h0},
    {2'd3, 8'h09, 1'b0, 12'd0, 32'h0}, {2'd3, 8'h0A, 1'b1, 12'd3, 32'h3456789A}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic put(input logic [1:0] f, input logic [7:0] d);
    @(negedge clk); fmt = f; wr_data = d; wr_stb = 1'b1;
    @(negedge clk); wr_stb = 1'b0;
  endtask

  task automatic put_word(input logic [7:0] b0, b1, b2, b3,
                          input logic [11:0] exp_addr, input string tag);
    put(2'd0, b0); put(2'd0, b1); put(2'd0, b2);
    chk({tag, " no early write"}, {31'b0, mem_we}, 32'd0);
    put(2'd0, b3);
    chk({tag, " we"}, {31'b0, mem_we}, 32'd1);
    chk({tag, " addr"}, {20'b0, mem_addr}, {20'b0, exp_addr});
    chk({tag, " word"}, mem_wdata, {b0, b1, b2, b3});
  endtask

  task automatic load(input bit do_row, input logic [7:0] r, input bit do_col, input logic [4:0] c);
    @(negedge clk); row_load = do_row; row_val = r; col_load = do_col; col_val = c;
    @(negedge clk); row_load = 1'b0; col_load = 1'b0;
  endtask

  task automatic rd(input logic [7:0] exp, input bit exp_re, input logic [11:0] exp_addr, input string tag);
    @(negedge clk); rd_stb = 1'b1;
    @(negedge clk); rd_stb = 1'b0;
    chk({tag, " data"}, {24'b0, rd_data}, {24'b0, exp});
    chk({tag, " re"}, {31'b0, mem_re}, {31'b0, exp_re});
    if (exp_re) chk({tag, " fetch addr"}, {20'b0, mem_addr}, {20'b0, exp_addr});
    repeat (3) @(negedge clk);
    chk({tag, " hold"}, {24'b0, rd_data}, {24'b0, exp});
  endtask

  initial begin
    for (int i = 0; i < 16; i++) bmem[i] = 32'h0;
    bmem[5] = 32'hDEADBEEF;
    bmem[6] = 32'h01234567;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk("R1 we", {31'b0, mem_we}, 32'd0);
    chk("R1 re", {31'b0, mem_re}, 32'd0);
    chk("R1 rd_data", {24'b0, rd_data}, 32'd0);
    chk("R1 addr", {20'b0, mem_addr}, 32'd0);

    // R2 R3 R4 R5 R6: vector walk starting at address 0
    for (int i = 0; i < 24; i++) begin
      logic [54:0] v;
      string tg;
      v = VEC[i];
      tg = (v[54:53] == 2'd0) ? "R2" : (v[54:53] == 2'd1) ? "R3" : "R4";
      put(v[54:53], v[52:45]);
      chk("R5 write pulse", {31'b0, mem_we}, {31'b0, v[44]});
      if (v[44]) begin
        chk({tg, " word"}, mem_wdata, v[31:0]);
        chk("R6 addr", {20'b0, mem_addr}, {20'b0, v[43:32]});
        @(negedge clk);
        chk("R5 single pulse", {31'b0, mem_we}, 32'd0);
      end
    end

    // R6: column wrap into the next row, then full address wrap
    load(1'b1, 8'd0, 1'b1, 5'd19);
    put_word(8'h11, 8'h22, 8'h33, 8'h44, 12'd19, "R6 col end");
    put_word(8'h55, 8'h66, 8'h77, 8'h88, 12'd20, "R6 next row");
    load(1'b1, 8'd159, 1'b1, 5'd19);
    put_word(8'h99, 8'hAA, 8'hBB, 8'hCC, 12'd3199, "R6 last addr");
    put_word(8'hDD, 8'hEE, 8'hFF, 8'h01, 12'd0, "R6 wrap");

    // R7: a load discards a partial word
    put(2'd0, 8'hAA); put(2'd0, 8'hBB);
    load(1'b0, 8'd0, 1'b1, 5'd7);
    put_word(8'h01, 8'h02, 8'h03, 8'h04, 12'd7, "R7 partial cleared");

    // R8 R9: dummy read then two word groups
    load(1'b1, 8'd0, 1'b1, 5'd5);
    rd(8'h00, 1'b1, 12'd5, "R8 dummy");
    rd(8'hDE, 1'b0, 12'd0, "R9 byte0");
    rd(8'hAD, 1'b0, 12'd0, "R9 byte1");
    rd(8'hBE, 1'b0, 12'd0, "R9 byte2");
    rd(8'hEF, 1'b1, 12'd6, "R9 byte3");
    rd(8'h01, 1'b0, 12'd0, "R9 next byte0");
    rd(8'h23, 1'b0, 12'd0, "R9 next byte1");
    rd(8'h45, 1'b0, 12'd0, "R9 next byte2");
    rd(8'h67, 1'b1, 12'd7, "R9 next byte3");

    // R7: reload re-arms the dummy read
    load(1'b0, 8'd0, 1'b1, 5'd5);
    rd(8'h00, 1'b1, 12'd5, "R7 dummy again");
    rd(8'hDE, 1'b0, 12'd0, "R7 first byte");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule